// File: doc/BRIEF.md
# Switch Lattice Literal Mapper

This block fills in the literal map for a rectangular lattice of four-terminal switches. Software or a host engine first writes two product tables. The column table holds the products of a target Boolean function, and the row table holds the products of that function's dual. Both are in irredundant sum-of-products form, and each product is a literal bitmask. A start strobe then fixes the lattice size. The block then visits every row/column site and computes the literals that the column product and the row product share. It picks one of those literals and streams it out together with the site coordinates.

Every site is handled in one cycle, and a valid/ready handshake paces the stream. For correct irredundant inputs, every site has at least one shared literal. When a site has none, the input tables were not a function/dual pair. In that case the block marks the site invalid and raises an error flag that stays set until the next accepted start.

Top module: `lattice_literal_mapper`

## Requirements
- R1: After reset the block is idle and its outputs read as follows: `busy`, `outValid`, `done` and `errFlag` are 0, and `latCols` and `latRows` are 0.
- R2: A write with `wrEn`=1 while idle stores `wrMask` at `wrAddr`. When `wrSel`=0 it goes to the column (target) table, and when `wrSel`=1 it goes to the row (dual) table. A write while busy has no effect on any later result.
- R3: A start while idle is accepted only when both requested counts lie between 1 and their table depth. An accepted start latches the counts onto `latCols` and `latRows` and raises `busy` in the next cycle. Any other start leaves `busy` low and the dimensions unchanged.
- R4: Sites are emitted in row-major order, starting at row 0 and column 0 with the column index advancing first. Each site is emitted exactly once. A site advances only on a cycle where `outValid` and `outReady` are both 1. While `outReady` is 0, all site outputs hold steady.
- R5: Each literal is encoded as bit 2i for variable i in true form and bit 2i+1 for variable i in complemented form. `outLit` is the index of the lowest set bit in the AND of the column mask and the row mask for that site.
- R6: A site whose masks share no literal is emitted with `outSiteOk`=0 and `outLit`=0. Once such a site is accepted, `errFlag` goes to 1 and stays there until the next accepted start clears it.
- R7: In the cycle after the last site is accepted, `busy` is 0 and `done` is 1 for exactly one cycle.
- R8: A start strobe while busy is ignored. The dimensions and the site sequence continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Product table write enable |
| wrSel | input | 1 | 0 selects the column table, 1 selects the row table |
| wrAddr | input | IDX_W | Table entry index |
| wrMask | input | 2*NUM_VARS | Literal mask of the product |
| start | input | 1 | Begin a mapping pass |
| cfgCols | input | CNT_W | Requested column count |
| cfgRows | input | CNT_W | Requested row count |
| outValid | output | 1 | Site record available |
| outReady | input | 1 | Consumer accepts the site record |
| outRow | output | IDX_W | Row of the current site |
| outCol | output | IDX_W | Column of the current site |
| outLit | output | LIT_IDX_W | Chosen literal index |
| outSiteOk | output | 1 | Site had a non-empty candidate set |
| latCols | output | CNT_W | Latched lattice column count |
| latRows | output | CNT_W | Latched lattice row count |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after the final site |
| errFlag | output | 1 | Sticky empty-intersection flag |

## Verification
A corrupted row or column index shows up at once as a wrong coordinate on the very next site record. It also shows up as a wrong literal, because the wrong table entries are then used for that site. A stale or overwritten table entry is exposed only at the sites in that row or column, so every random pass compares each site against a model of the tables. A wrong handshake state would surface within one cycle of backpressure, either as coordinates that move while `outReady` is low or as a site that is skipped or repeated. A bad end-of-pass condition appears as a missing or late `done` pulse, or as `busy` staying high past the last site.

// File: rtl/lattice_map_pkg.sv
package lattice_map_pkg;

  typedef enum logic {
    CTRL_IDLE = 1'b0,
    CTRL_RUN  = 1'b1
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrAllow;
    logic latchDims;
    logic clearErr;
    logic siteFire;
  } ctrlStrobe_t;

endpackage

// File: rtl/lattice_lowbit_pick.sv
module lattice_lowbit_pick #(
  parameter int WIDTH = 10,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [IDX_W-1:0] lowIdx,
  output logic             anySet
);

  // masked prefix: bit i is kept only if no lower bit is set
  logic [WIDTH-1:0] lowerSeen;
  logic [WIDTH-1:0] firstHot;

  assign lowerSeen[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 1; gi < WIDTH; gi++) begin : gPrefix
      assign lowerSeen[gi] = lowerSeen[gi-1] | vecIn[gi-1];
    end
  endgenerate

  assign firstHot = vecIn & ~lowerSeen;
  assign anySet   = |vecIn;

  always_comb begin
    lowIdx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (firstHot[i]) lowIdx = lowIdx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/lattice_map_ctrl.sv
module lattice_map_ctrl
  import lattice_map_pkg::*;
#(
  parameter int MAX_COLS = 8,
  parameter int MAX_ROWS = 8,
  localparam int MAX_DIM = (MAX_COLS > MAX_ROWS) ? MAX_COLS : MAX_ROWS,
  localparam int IDX_W   = (MAX_DIM > 1) ? $clog2(MAX_DIM) : 1,
  localparam int CNT_W   = $clog2(MAX_DIM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfgCols,
  input  logic [CNT_W-1:0]  cfgRows,
  input  logic              outReady,
  input  logic [CNT_W-1:0]  dimCols,
  input  logic [CNT_W-1:0]  dimRows,
  output ctrlStrobe_t       strobe,
  output logic [IDX_W-1:0]  rowIdx,
  output logic [IDX_W-1:0]  colIdx,
  output logic              busy,
  output logic              donePulse
);

  ctrlState_e state;
  logic       cfgOk;
  logic       lastCol;
  logic       lastRow;

  assign cfgOk = (cfgCols != '0) && (cfgRows != '0) &&
                 (cfgCols <= CNT_W'(MAX_COLS)) && (cfgRows <= CNT_W'(MAX_ROWS));

  assign lastCol = (CNT_W'(colIdx) + CNT_W'(1)) == dimCols;
  assign lastRow = (CNT_W'(rowIdx) + CNT_W'(1)) == dimRows;
  assign busy    = (state == CTRL_RUN);

  always_comb begin
    strobe           = '0;
    strobe.wrAllow   = (state == CTRL_IDLE);
    strobe.latchDims = (state == CTRL_IDLE) && start && cfgOk;
    strobe.clearErr  = (state == CTRL_IDLE) && start && cfgOk;
    strobe.siteFire  = (state == CTRL_RUN) && outReady;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CTRL_IDLE;
      rowIdx    <= '0;
      colIdx    <= '0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      unique case (state)
        CTRL_IDLE: begin
          if (strobe.latchDims) begin
            state  <= CTRL_RUN;
            rowIdx <= '0;
            colIdx <= '0;
          end
        end
        CTRL_RUN: begin
          if (strobe.siteFire) begin
            if (lastCol) begin
              colIdx <= '0;
              if (lastRow) begin
                state     <= CTRL_IDLE;
                rowIdx    <= '0;
                donePulse <= 1'b1;
              end else begin
                rowIdx <= rowIdx + IDX_W'(1);
              end
            end else begin
              colIdx <= colIdx + IDX_W'(1);
            end
          end
        end
        default: state <= CTRL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lattice_map_datapath.sv
module lattice_map_datapath
  import lattice_map_pkg::*;
#(
  parameter int NUM_VARS = 5,
  parameter int MAX_COLS = 8,
  parameter int MAX_ROWS = 8,
  localparam int LIT_W     = 2 * NUM_VARS,
  localparam int LIT_IDX_W = (LIT_W > 1) ? $clog2(LIT_W) : 1,
  localparam int MAX_DIM   = (MAX_COLS > MAX_ROWS) ? MAX_COLS : MAX_ROWS,
  localparam int IDX_W     = (MAX_DIM > 1) ? $clog2(MAX_DIM) : 1,
  localparam int CNT_W     = $clog2(MAX_DIM + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strobe,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [IDX_W-1:0]     wrAddr,
  input  logic [LIT_W-1:0]     wrMask,
  input  logic [CNT_W-1:0]     cfgCols,
  input  logic [CNT_W-1:0]     cfgRows,
  input  logic [IDX_W-1:0]     rowIdx,
  input  logic [IDX_W-1:0]     colIdx,
  output logic [CNT_W-1:0]     dimCols,
  output logic [CNT_W-1:0]     dimRows,
  output logic [LIT_IDX_W-1:0] litIdx,
  output logic                 siteOk,
  output logic                 errFlag
);

  logic [LIT_W-1:0] colTable [MAX_COLS];
  logic [LIT_W-1:0] rowTable [MAX_ROWS];
  logic [LIT_W-1:0] colProd;
  logic [LIT_W-1:0] rowProd;
  logic [LIT_W-1:0] candidates;

  // table writes, one per table
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_COLS; i++) colTable[i] <= '0;
    end else if (wrEn && strobe.wrAllow && !wrSel && (int'(wrAddr) < MAX_COLS)) begin
      colTable[wrAddr] <= wrMask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_ROWS; i++) rowTable[i] <= '0;
    end else if (wrEn && strobe.wrAllow && wrSel && (int'(wrAddr) < MAX_ROWS)) begin
      rowTable[wrAddr] <= wrMask;
    end
  end

  always_comb begin
    colProd = '0;
    rowProd = '0;
    if (int'(colIdx) < MAX_COLS) colProd = colTable[colIdx];
    if (int'(rowIdx) < MAX_ROWS) rowProd = rowTable[rowIdx];
  end

  assign candidates = colProd & rowProd;

  lattice_lowbit_pick #(.WIDTH(LIT_W)) pick_i (
    .vecIn  (candidates),
    .lowIdx (litIdx),
    .anySet (siteOk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dimCols <= '0;
      dimRows <= '0;
    end else if (strobe.latchDims) begin
      dimCols <= cfgCols;
      dimRows <= cfgRows;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errFlag <= 1'b0;
    end else if (strobe.clearErr) begin
      errFlag <= 1'b0;
    end else if (strobe.siteFire && !siteOk) begin
      errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/lattice_literal_mapper.sv
module lattice_literal_mapper
  import lattice_map_pkg::*;
#(
  parameter int NUM_VARS = 5,
  parameter int MAX_COLS = 8,
  parameter int MAX_ROWS = 8,
  localparam int LIT_W     = 2 * NUM_VARS,
  localparam int LIT_IDX_W = (LIT_W > 1) ? $clog2(LIT_W) : 1,
  localparam int MAX_DIM   = (MAX_COLS > MAX_ROWS) ? MAX_COLS : MAX_ROWS,
  localparam int IDX_W     = (MAX_DIM > 1) ? $clog2(MAX_DIM) : 1,
  localparam int CNT_W     = $clog2(MAX_DIM + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [IDX_W-1:0]     wrAddr,
  input  logic [LIT_W-1:0]     wrMask,
  input  logic                 start,
  input  logic [CNT_W-1:0]     cfgCols,
  input  logic [CNT_W-1:0]     cfgRows,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [IDX_W-1:0]     outRow,
  output logic [IDX_W-1:0]     outCol,
  output logic [LIT_IDX_W-1:0] outLit,
  output logic                 outSiteOk,
  output logic [CNT_W-1:0]     latCols,
  output logic [CNT_W-1:0]     latRows,
  output logic                 busy,
  output logic                 done,
  output logic                 errFlag
);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] rowIdx;
  logic [IDX_W-1:0] colIdx;

  lattice_map_ctrl #(
    .MAX_COLS (MAX_COLS),
    .MAX_ROWS (MAX_ROWS)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfgCols   (cfgCols),
    .cfgRows   (cfgRows),
    .outReady  (outReady),
    .dimCols   (latCols),
    .dimRows   (latRows),
    .strobe    (strobe),
    .rowIdx    (rowIdx),
    .colIdx    (colIdx),
    .busy      (busy),
    .donePulse (done)
  );

  lattice_map_datapath #(
    .NUM_VARS (NUM_VARS),
    .MAX_COLS (MAX_COLS),
    .MAX_ROWS (MAX_ROWS)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrAddr  (wrAddr),
    .wrMask  (wrMask),
    .cfgCols (cfgCols),
    .cfgRows (cfgRows),
    .rowIdx  (rowIdx),
    .colIdx  (colIdx),
    .dimCols (latCols),
    .dimRows (latRows),
    .litIdx  (outLit),
    .siteOk  (outSiteOk),
    .errFlag (errFlag)
  );

  assign outValid = busy;
  assign outRow   = rowIdx;
  assign outCol   = colIdx;

endmodule

// File: rtl/lattice_map_checker.sv
module lattice_map_checker #(
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4,
  parameter int LIT_IDX_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 outValid,
  input logic                 outReady,
  input logic [IDX_W-1:0]     outRow,
  input logic [IDX_W-1:0]     outCol,
  input logic [LIT_IDX_W-1:0] outLit,
  input logic                 outSiteOk,
  input logic [CNT_W-1:0]     latCols,
  input logic [CNT_W-1:0]     latRows,
  input logic                 busy,
  input logic                 done,
  input logic                 errFlag
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !outValid);

  assert_site_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (CNT_W'(outRow) < latRows) && (CNT_W'(outCol) < latCols));

  assert_hold_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outRow) && $stable(outCol) && $stable(outLit));

  assert_err_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && outReady && !outSiteOk |=> errFlag);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag && !(start && !busy) |=> errFlag);

  assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  assert_dims_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(latCols) && $stable(latRows));

endmodule

bind lattice_literal_mapper lattice_map_checker #(
  .IDX_W     (IDX_W),
  .CNT_W     (CNT_W),
  .LIT_IDX_W (LIT_IDX_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .outValid  (outValid),
  .outReady  (outReady),
  .outRow    (outRow),
  .outCol    (outCol),
  .outLit    (outLit),
  .outSiteOk (outSiteOk),
  .latCols   (latCols),
  .latRows   (latRows),
  .busy      (busy),
  .done      (done),
  .errFlag   (errFlag)
);

// File: tb/lattice_literal_mapper_tb_top.sv
`timescale 1ns/1ps
module lattice_literal_mapper_tb_top;

  localparam int NV    = 5;
  localparam int MC    = 8;
  localparam int MR    = 8;
  localparam int LW    = 2 * NV;
  localparam int LIW   = $clog2(LW);
  localparam int IW    = 3;
  localparam int CW    = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wrEn = 1'b0;
  logic           wrSel = 1'b0;
  logic [IW-1:0]  wrAddr = '0;
  logic [LW-1:0]  wrMask = '0;
  logic           start = 1'b0;
  logic [CW-1:0]  cfgCols = '0;
  logic [CW-1:0]  cfgRows = '0;
  logic           outValid;
  logic           outReady = 1'b0;
  logic [IW-1:0]  outRow;
  logic [IW-1:0]  outCol;
  logic [LIW-1:0] outLit;
  logic           outSiteOk;
  logic [CW-1:0]  latCols;
  logic [CW-1:0]  latRows;
  logic           busy;
  logic           done;
  logic           errFlag;

  int total = 0;
  int bad   = 0;
  logic [LW-1:0] mCol [MC];
  logic [LW-1:0] mRow [MR];

  always #2 clk = ~clk;

  lattice_literal_mapper #(.NUM_VARS(NV), .MAX_COLS(MC), .MAX_ROWS(MR)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr),
    .wrMask(wrMask), .start(start), .cfgCols(cfgCols), .cfgRows(cfgRows),
    .outValid(outValid), .outReady(outReady), .outRow(outRow), .outCol(outCol),
    .outLit(outLit), .outSiteOk(outSiteOk), .latCols(latCols), .latRows(latRows),
    .busy(busy), .done(done), .errFlag(errFlag)
  );

  function automatic int lowestLit(logic [LW-1:0] m);
    for (int i = 0; i < LW; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic putProd(logic sel, int addr, logic [LW-1:0] m);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrAddr = IW'(addr); wrMask = m;
    @(negedge clk);
    wrEn = 1'b0;
    if (sel) mRow[addr] = m; else mCol[addr] = m;
  endtask

  // runs a pass and checks every site; disturb injects a write and a start mid-run
  task automatic runPass(int cols, int rows, bit stall, bit disturb);
    bit anyEmpty = 0;
    int k = 0;
    @(negedge clk);
    start = 1'b1; cfgCols = CW'(cols); cfgRows = CW'(rows);
    @(negedge clk);
    start = 1'b0;
    check("R3", "busy after start", int'(busy), 1);
    check("R3", "latCols", int'(latCols), cols);
    check("R3", "latRows", int'(latRows), rows);
    check("R6", "err cleared by start", int'(errFlag), 0);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        bit rdy;
        logic [LW-1:0] cand = mCol[c] & mRow[r];
        int el = lowestLit(cand);
        do begin
          rdy = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
          outReady = rdy;
          if (disturb && k == 1) begin
            wrEn = 1'b1; wrSel = 1'b0; wrAddr = '0; wrMask = '1;
            start = 1'b1; cfgCols = 4'd1; cfgRows = 4'd1;
          end
          if (!outValid) check("R4", "valid during pass", 0, 1);
          if (!rdy) begin
            logic [IW-1:0] hr = outRow;
            logic [IW-1:0] hc = outCol;
            logic [LIW-1:0] hl = outLit;
            @(negedge clk);
            wrEn = 1'b0; start = 1'b0;
            check("R4", "row held", int'(outRow), int'(hr));
            check("R4", "col held", int'(outCol), int'(hc));
            check("R4", "lit held", int'(outLit), int'(hl));
          end
        end while (!rdy);
        check("R4", "row order", int'(outRow), r);
        check("R4", "col order", int'(outCol), c);
        if (el >= 0) begin
          check("R5", "literal", int'(outLit), el);
          check("R5", "site ok", int'(outSiteOk), 1);
        end else begin
          anyEmpty = 1;
          check("R6", "site invalid", int'(outSiteOk), 0);
          check("R6", "literal zero", int'(outLit), 0);
        end
        k++;
        @(negedge clk);
        wrEn = 1'b0; start = 1'b0; outReady = 1'b0;
        if (disturb && k == 2) begin
          check("R8", "dims kept cols", int'(latCols), cols);
          check("R8", "dims kept rows", int'(latRows), rows);
        end
      end
    end
    check("R7", "done pulse", int'(done), 1);
    check("R7", "busy low", int'(busy), 0);
    check("R6", "err flag", int'(errFlag), int'(anyEmpty));
    @(negedge clk);
    check("R7", "done single cycle", int'(done), 0);
    check("R6", "err sticky idle", int'(errFlag), int'(anyEmpty));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R4 watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    for (int i = 0; i < MC; i++) mCol[i] = '0;
    for (int i = 0; i < MR; i++) mRow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy", int'(busy), 0);
    check("R1", "valid", int'(outValid), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "err", int'(errFlag), 0);
    check("R1", "latCols", int'(latCols), 0);
    check("R1", "latRows", int'(latRows), 0);

    // worked example: x1x2x3 + x1x4 + x1x5 and its dual, bit 2i = x(i+1)
    putProd(1'b0, 0, 10'b0000010101);
    putProd(1'b0, 1, 10'b0001000001);
    putProd(1'b0, 2, 10'b0100000001);
    putProd(1'b1, 0, 10'b0000000001);
    putProd(1'b1, 1, 10'b0101000100);
    putProd(1'b1, 2, 10'b0101010000);
    runPass(3, 3, 1'b0, 1'b0);
    runPass(3, 3, 1'b1, 1'b0);

    // invalid start requests: zero and over-depth counts (R3)
    @(negedge clk);
    start = 1'b1; cfgCols = 4'd0; cfgRows = 4'd2;
    @(negedge clk);
    start = 1'b0;
    check("R3", "zero count ignored", int'(busy), 0);
    check("R3", "dims unchanged", int'(latCols), 3);
    start = 1'b1; cfgCols = 4'd2; cfgRows = 4'd9;
    @(negedge clk);
    start = 1'b0;
    check("R3", "over depth ignored", int'(busy), 0);
    check("R3", "rows unchanged", int'(latRows), 3);

    // mid-run write and start must not alter results (R2, R8); model unchanged
    runPass(3, 3, 1'b0, 1'b1);
    runPass(3, 3, 1'b0, 1'b0);

    // empty intersection site (R6) then recovery by next start
    putProd(1'b0, 0, 10'b0000000001);
    putProd(1'b1, 0, 10'b0000000010);
    runPass(1, 1, 1'b0, 1'b0);
    putProd(1'b1, 0, 10'b0000000011);
    runPass(1, 1, 1'b0, 1'b0);

    // complemented-literal positions (R5)
    putProd(1'b0, 0, 10'b1000000000);
    putProd(1'b1, 0, 10'b1100000000);
    runPass(1, 1, 1'b0, 1'b0);

    // full-size corner and random passes
    for (int t = 0; t < 24; t++) begin
      int nc = (t == 0) ? MC : int'($urandom_range(1, MC));
      int nr = (t == 0) ? MR : int'($urandom_range(1, MR));
      for (int i = 0; i < nc; i++) putProd(1'b0, i, LW'($urandom) | LW'(1 << (t % LW)));
      for (int i = 0; i < nr; i++) putProd(1'b1, i, LW'($urandom));
      runPass(nc, nr, (t % 2) == 1, (t % 5) == 3);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule